// File: doc/BRIEF.md
# Split-Word Trace Record Buffer

This block holds 64-bit trace records in an internal first-in first-out store and hands them to a CPU or DMA engine through a narrow 32-bit read port. Each record is fetched as two words. The low half is read first and has no side effect. The high half is read second, and that read retires the record so the next one moves to the head. A producer pushes whole records through a one-cycle write strobe.

A programmable fill threshold watches the number of stored records. When the count reaches the threshold, the block raises either an interrupt or a DMA request, as chosen by a routing bit. That request stays up until draining brings the count back under the threshold. Two fault conditions stay visible through a status word: reads issued while the store was empty, and records lost because the store was full.

Top module: `trace_rec_buf`

## Requirements
- R1: After reset the store is empty, the status word (address 2) and the configuration word (address 3) read zero, and both request outputs are low.
- R2: Records come out in write order; address 0 returns record bits [31:0] and address 1 returns bits [63:32] of the head record.
- R3: A read at address 0 never retires a record; repeated reads return the same value and leave the count unchanged.
- R4: A read at address 1 while the store is not empty retires the head record, lowering the count by one on the next cycle.
- R5: A read at address 0 or 1 while empty returns zero, retires nothing and sets a sticky underflow flag at status bit 31, which is cleared only by reset.
- R6: The store holds DEPTH (512) records; a write while full is discarded and increments an 8-bit overflow counter at status bits [23:16], which saturates at 255. Status bits [9:0] hold the record count.
- R7: Writing the configuration stores the threshold in bits [15:0] and the routing bit in bit 31 of address 3; a threshold above DEPTH is clamped to DEPTH.
- R8: With a nonzero threshold, the selected request is high exactly while count >= threshold; a threshold of zero keeps both requests low.
- R9: Routing bit 0 drives the interrupt output and routing bit 1 drives the DMA request output; the two are never high together, and a threshold of 500 is supported.
- R10: A write and a retiring read in the same cycle on a non-full, non-empty store leave the count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record write strobe |
| rec_data | input | 64 | Record to store |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register select: 0 low, 1 high, 2 status, 3 configuration |
| rd_data | output | 32 | Read data, valid in the cycle of rd_en |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_level | input | 16 | Requested fill threshold |
| cfg_route | input | 1 | Request routing: 0 interrupt, 1 DMA |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A wrong read pointer or count shows up on the very next word read as a record that does not match the write order, or as a status count that differs from the number of writes minus retiring reads. A threshold compare that is off by one shows as a request edge one record early or late, which appears within the same cycle that the count changes. Lost or spurious overflow and underflow bookkeeping appears in the status word at the next read of address 2, which the bench checks against its own model after random mixes of writes, reads and reconfigurations.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CFG  = 2'd3;

  function automatic int unsigned clamp_lvl(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  function automatic logic trig_hit(input int unsigned cnt, input int unsigned lvl);
    return (lvl != 0) && (cnt >= lvl);
  endfunction
endpackage

// File: rtl/tf_store.sv
module tf_store #(
  parameter int DEPTH = 512,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full  = (32'(count) == DEPTH);
  assign empty = (count == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
  p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
  p_both_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> $stable(count));
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/tf_trig.sv
module tf_trig #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          route,
  output logic          irq,
  output logic          dma_req
);
  import tf_pkg::*;
  logic hit;

  assign hit     = trig_hit(32'(count), 32'(level));
  assign irq     = hit && !route;
  assign dma_req = hit && route;

  p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));
  p_rise_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || dma_req) |-> (level != '0 && count >= level));
  p_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !(irq || dma_req));
endmodule

// File: rtl/tf_regs.sv
module tf_regs #(
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  parameter int LW    = 16,
  parameter int OW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  input  logic [63:0]   head,
  input  logic          empty,
  input  logic [CW-1:0] count,
  input  logic          drop,
  input  logic          cfg_wr,
  input  logic [LW-1:0] cfg_level,
  input  logic          cfg_route,
  output logic [31:0]   rd_data,
  output logic          pop,
  output logic [CW-1:0] level,
  output logic          route
);
  import tf_pkg::*;
  localparam logic [OW-1:0] OMAX = '1;

  logic          und;
  logic [OW-1:0] ovf;
  logic          word_rd, und_ev;

  assign word_rd = rd_en && (rd_addr == A_LO || rd_addr == A_HI);
  assign und_ev  = word_rd && empty;
  assign pop     = rd_en && (rd_addr == A_HI) && !empty;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_LO:    rd_data = empty ? '0 : head[31:0];
        A_HI:    rd_data = empty ? '0 : head[63:32];
        A_STAT:  rd_data = 32'(count) | (32'(ovf) << 16) | (32'(und) << 31);
        default: rd_data = 32'(level) | (32'(route) << 31);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      und <= 1'b0; ovf <= '0; level <= '0; route <= 1'b0;
    end else begin
      if (und_ev) und <= 1'b1;
      if (drop && ovf != OMAX) ovf <= ovf + 1'b1;
      if (cfg_wr) begin
        level <= CW'(clamp_lvl(32'(cfg_level), DEPTH));
        route <= cfg_route;
      end
    end
  end

  p_lo_no_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_LO) |-> !pop);
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && empty) |-> (rd_data == '0 && !pop));
  p_und_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    und |=> und);
  p_ovf_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == OMAX) |=> (ovf == OMAX));
  p_lvl_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
endmodule

// File: rtl/trace_rec_buf.sv
module trace_rec_buf #(
  parameter int DEPTH = 512,
  parameter int LW    = 16,
  parameter int OW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rec_valid,
  input  logic [63:0] rec_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_level,
  input  logic        cfg_route,
  output logic        irq,
  output logic        dma_req
);
  logic [63:0]   head;
  logic [CW-1:0] count, level;
  logic          full, empty, push, pop, drop, route;

  assign push = rec_valid && !full;
  assign drop = rec_valid && full;

  tf_store #(.DEPTH(DEPTH), .W(64)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(rec_data),
    .head(head), .count(count), .full(full), .empty(empty));

  tf_regs #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .OW(OW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .head(head),
    .empty(empty), .count(count), .drop(drop), .cfg_wr(cfg_wr),
    .cfg_level(LW'(cfg_level)), .cfg_route(cfg_route), .rd_data(rd_data),
    .pop(pop), .level(level), .route(route));

  tf_trig #(.CW(CW)) u_trig (
    .clk(clk), .rst_n(rst_n), .count(count), .level(level), .route(route),
    .irq(irq), .dma_req(dma_req));

  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (32'(count) == DEPTH || $past(pop)));
endmodule

// File: tb/sim_trace_rec_buf.sv
module sim_trace_rec_buf;
  localparam int DEPTH = 512;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_valid = 0, rd_en = 0, cfg_wr = 0, cfg_route = 0;
  logic [63:0] rec_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] cfg_level = '0;
  logic [31:0] rd_data;
  logic irq, dma_req;

  int checks = 0, errors = 0;
  logic [63:0] q[$];
  int m_ovf = 0, m_lvl = 0;
  bit m_und = 0, m_route = 0;

  always #5 clk = ~clk;

  trace_rec_buf u0 (.clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_wr(cfg_wr),
    .cfg_level(cfg_level), .cfg_route(cfg_route), .irq(irq), .dma_req(dma_req));

  function automatic logic [31:0] exp_stat();
    return {m_und, 7'd0, 8'(m_ovf), 6'd0, 10'(q.size())};
  endfunction
  function automatic logic [31:0] exp_cfg();
    return {m_route, 15'd0, 16'(m_lvl)};
  endfunction
  function automatic bit exp_hit();
    return m_lvl > 0 && q.size() >= m_lvl;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [63:0] d, input bit rd, input logic [1:0] a,
                      input bit cw, input logic [15:0] cl, input bit cr);
    logic [31:0] e;
    bit pop_ok, push_ok;
    @(negedge clk);
    rec_valid = wr; rec_data = d; rd_en = rd; rd_addr = a;
    cfg_wr = cw; cfg_level = cl; cfg_route = cr;
    #1;
    if (rd) begin
      case (a)
        2'd0: e = q.size() > 0 ? q[0][31:0] : 32'd0;
        2'd1: e = q.size() > 0 ? q[0][63:32] : 32'd0;
        2'd2: e = exp_stat();
        default: e = exp_cfg();
      endcase
      chk(rd_data === e, a == 2'd2 ? "R6 status" : a == 2'd3 ? "R7 config" :
          q.size() == 0 ? "R5 empty read" : "R2 record word", 64'(rd_data), 64'(e));
    end
    @(posedge clk);
    pop_ok  = rd && a == 2'd1 && q.size() > 0;
    push_ok = wr && q.size() < DEPTH;
    if (rd && a < 2'd2 && q.size() == 0) m_und = 1;
    if (wr && !push_ok && m_ovf < 255) m_ovf++;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(d);
    if (cw) begin
      m_lvl = (cl > DEPTH) ? DEPTH : int'(cl);
      m_route = cr;
    end
    #1;
    chk(irq === (exp_hit() && !m_route), "R8 irq", 64'(irq), 64'(exp_hit() && !m_route));
    chk(dma_req === (exp_hit() && m_route), "R9 dma_req", 64'(dma_req), 64'(exp_hit() && m_route));
  endtask

  task automatic idle(); step(0, '0, 0, 2'd0, 0, '0, 0); endtask
  task automatic wr(input logic [63:0] d); step(1, d, 0, 2'd0, 0, '0, 0); endtask
  task automatic rd(input logic [1:0] a); step(0, '0, 1, a, 0, '0, 0); endtask
  task automatic cfg(input logic [15:0] l, input bit r); step(0, '0, 0, 2'd0, 1, l, r); endtask
  function automatic logic [63:0] rnd64(); return {$urandom(), $urandom()}; endfunction

  initial begin
    int unsigned seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(2'd2); rd(2'd3);
    chk(irq === 0 && dma_req === 0, "R1 outputs after reset", {irq, dma_req}, 0);
    // R5 empty reads
    rd(2'd0); rd(2'd1); rd(2'd2);
    // R3 low-word reads do not pop; R2 order; R4 high pops
    for (int i = 0; i < 5; i++) wr(rnd64());
    rd(2'd0); rd(2'd0); rd(2'd2);
    rd(2'd1); rd(2'd2);
    for (int i = 0; i < 4; i++) begin rd(2'd0); rd(2'd1); end
    rd(2'd2);
    // R10 simultaneous write and pop
    wr(rnd64()); wr(rnd64());
    step(1, rnd64(), 1, 2'd1, 0, '0, 0);
    rd(2'd2); rd(2'd0); rd(2'd1); rd(2'd0); rd(2'd1);
    // R9 threshold of 500 on interrupt, then DMA
    cfg(16'd500, 0); rd(2'd3);
    for (int i = 0; i < 500; i++) wr(rnd64());
    chk(irq === 1, "R9 irq at 500", 64'(irq), 1);
    cfg(16'd500, 1);
    chk(dma_req === 1 && irq === 0, "R9 dma route", {irq, dma_req}, 1);
    rd(2'd0); rd(2'd1);
    chk(dma_req === 0, "R8 drop below level", 64'(dma_req), 0);
    // R7 clamp
    cfg(16'd1000, 0); rd(2'd3);
    // R6 fill and overflow saturation
    for (int i = 0; i < 320; i++) wr(rnd64());
    rd(2'd2);
    step(1, rnd64(), 1, 2'd1, 0, '0, 0);
    rd(2'd2);
    cfg(16'd0, 0);
    while (q.size() > 0) begin rd(2'd0); rd(2'd1); end
    rd(2'd1); rd(2'd2);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 15);
      if (k == 0) cfg(16'($urandom_range(0, 600)), 1'($urandom()));
      else step(1'($urandom_range(0, 1)), rnd64(), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3)), 0, '0, 0);
    end
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule